// File: doc/BRIEF.md
# Channel Status Bit Source

This block supplies the channel-status (C) bit that a two-channel digital audio frame encoder inserts into each subframe of a 192-frame block. The encoder presents the current frame number and which subframe (left or right) it is building. The block returns the matching C bit combinationally, so the encoder can use it in the same cycle.

Two sources are available, chosen by a select input. In pin mode, four static configuration pins fill in the main consumer and professional fields, and every other bit of the block is zero. In serial mode, a full 192-frame block of left and right C bits is shifted in from a data pin. A rising edge of the frame sync captures the bit for the left subframe. A falling edge captures the bit for the right subframe and moves on to the next frame. Captured bits collect in a shadow store. A block-start pulse copies the shadow store into the active store that feeds the output, and restarts capture at frame 0. The encoder therefore never transmits a block that is only partly updated.

All inputs are synchronous to `clk`. The frame sync is a level that the block samples and edge-detects on `clk`.

Top module: `cs_bit_source`

## Requirements
- R1: After a synchronous reset, every bit of the shadow and active stores is 0. In serial mode, `cs_bit` is therefore 0 for every frame and subframe until a block is loaded.
- R2: In pin mode (`src_serial`=0), if `pin_copy_ok`=1 and `pin_gen`=1, the block is professional. Bit 0 is 1, bit 1 equals `pin_non_pcm`, bit 2 is 1, bit 3 equals `pin_emph`, and bit 15 is 0.
- R3: In pin mode with any other `pin_copy_ok`/`pin_gen` combination, the block is consumer. Bit 0 is 0, bit 1 equals `pin_non_pcm`, bit 2 equals `pin_copy_ok`, bit 3 equals `pin_emph`, and bit 15 equals `pin_gen`.
- R4: In pin mode, every bit position other than 0, 1, 2, 3 and 15 is 0, and the left and right subframes carry identical bits.
- R5: In serial mode, a rising edge of `frm_sync` stores `ser_data` as the left bit of the frame at the capture pointer. A falling edge stores `ser_data` as the right bit of that frame and then advances the pointer by one.
- R6: A one-cycle `blk_start` pulse copies the shadow store into the active store and resets the capture pointer to frame 0. From the cycle after the pulse, `cs_bit` reflects the copied block.
- R7: Between `blk_start` pulses, the active store does not change. Bits shifted in during a block do not appear at `cs_bit` until the next pulse.
- R8: After 192 frames have been captured, further sync edges are ignored until the next `blk_start`.
- R9: For `frame_idx` of 192 or more, `cs_bit` is 0 in both modes.
- R10: A sync edge that occurs in the same cycle as `blk_start` is discarded. The pointer restarts at 0, and the next falling edge writes frame 0 right.
- R11: In pin mode, sync edges do not write the shadow store or move the capture pointer.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_serial | input | 1 | 0 = pin mode, 1 = serial mode |
| frm_sync | input | 1 | Frame sync level; rising edge selects left, falling edge selects right |
| ser_data | input | 1 | Serial channel-status data |
| blk_start | input | 1 | One-cycle pulse at the block boundary |
| pin_copy_ok | input | 1 | Copy-permission pin |
| pin_gen | input | 1 | Generation pin; when high together with `pin_copy_ok`, selects professional |
| pin_non_pcm | input | 1 | Marks non-PCM data |
| pin_emph | input | 1 | Marks 50/15 us pre-emphasis |
| frame_idx | input | 8 | Current frame number within the block |
| sub_right | input | 1 | 0 = left subframe, 1 = right subframe |
| cs_bit | output | 1 | Channel-status bit for the addressed subframe |

## Verification
A wrong capture pointer shows up as bits landing in the wrong frame. This appears at `cs_bit` once the next `blk_start` copies the shadow store, one clock after the pulse. A stuck or early shadow-to-active copy shows up as a new pattern appearing mid-block, before the boundary pulse. A left/right swap or a bad pin-mode field mapping is visible at once, because the read path is combinational. The bench sweeps every frame and subframe for each case, so a single misplaced bit is found within one full readout.

// File: rtl/cs_src_pkg.sv
package cs_src_pkg;

    localparam int unsigned CS_FRAMES = 192;

    // Bit positions used in pin mode
    localparam int unsigned POS_PRO    = 0;
    localparam int unsigned POS_NONPCM = 1;
    localparam int unsigned POS_COPY   = 2;
    localparam int unsigned POS_EMPH   = 3;
    localparam int unsigned POS_GEN    = 15;

    typedef enum logic {
        SRC_PINS   = 1'b0,
        SRC_SERIAL = 1'b1
    } cs_src_e;

    typedef struct packed {
        logic copy_ok;
        logic gen_flag;
        logic non_pcm;
        logic emph;
    } cs_pins_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sync_edge_t;

    function automatic logic pin_bit(input cs_pins_t p, input int unsigned idx);
        logic pro;
        logic b;
        pro = p.copy_ok & p.gen_flag;
        b   = 1'b0;
        if (idx == POS_PRO)         b = pro;
        else if (idx == POS_NONPCM) b = p.non_pcm;
        else if (idx == POS_COPY)   b = pro | p.copy_ok;
        else if (idx == POS_EMPH)   b = p.emph;
        else if (idx == POS_GEN)    b = ~pro & p.gen_flag;
        return b;
    endfunction

endpackage

// File: rtl/cs_sync_edge.sv
module cs_sync_edge
    import cs_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    output sync_edge_t edges
);
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_in;
    end

    always_comb begin
        edges.rise = sync_in & ~sync_q;
        edges.fall = ~sync_in & sync_q;
    end
endmodule

// File: rtl/cs_shadow_cap.sv
module cs_shadow_cap
    import cs_src_pkg::*;
#(
    parameter int unsigned FRAMES = CS_FRAMES,
    localparam int unsigned IDX_W = $clog2(FRAMES),
    localparam int unsigned PTR_W = $clog2(FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  sync_edge_t        edges,
    input  logic              blk_start,
    input  logic              bit_in,
    output logic [FRAMES-1:0] sh_l,
    output logic [FRAMES-1:0] sh_r,
    output logic [PTR_W-1:0]  ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(FRAMES);

    logic [IDX_W-1:0] wr_idx;
    assign wr_idx = ptr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            sh_l <= '0;
            sh_r <= '0;
        end else if (blk_start) begin
            ptr <= '0;
        end else if (enable && (ptr < LAST)) begin
            if (edges.rise) sh_l[wr_idx] <= bit_in;
            if (edges.fall) begin
                sh_r[wr_idx] <= bit_in;
                ptr          <= ptr + PTR_W'(1);
            end
        end
    end
endmodule

// File: rtl/cs_active_buf.sv
module cs_active_buf
    import cs_src_pkg::*;
#(
    parameter int unsigned FRAMES = CS_FRAMES,
    localparam int unsigned IDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [FRAMES-1:0] sh_l,
    input  logic [FRAMES-1:0] sh_r,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_right,
    output logic [FRAMES-1:0] act_l,
    output logic [FRAMES-1:0] act_r,
    output logic              rd_bit
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(FRAMES);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_l <= '0;
            act_r <= '0;
        end else if (load) begin
            act_l <= sh_l;
            act_r <= sh_r;
        end
    end

    always_comb begin
        rd_bit = 1'b0;
        if ({1'b0, rd_idx} < LIMIT) begin
            rd_bit = rd_right ? act_r[rd_idx] : act_l[rd_idx];
        end
    end
endmodule

// File: rtl/cs_bit_source.sv
module cs_bit_source
    import cs_src_pkg::*;
#(
    parameter int unsigned FRAMES = CS_FRAMES,
    localparam int unsigned IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_serial,
    input  logic             frm_sync,
    input  logic             ser_data,
    input  logic             blk_start,
    input  logic             pin_copy_ok,
    input  logic             pin_gen,
    input  logic             pin_non_pcm,
    input  logic             pin_emph,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             sub_right,
    output logic             cs_bit
);
    localparam int unsigned PTR_W = $clog2(FRAMES + 1);

    cs_src_e           src_mode;
    cs_pins_t          pins;
    sync_edge_t        sync_edge;
    logic [FRAMES-1:0] sh_l, sh_r, act_l, act_r;
    logic [PTR_W-1:0]  cap_ptr;
    logic              ser_bit;
    logic              pin_out;

    assign src_mode = cs_src_e'(src_serial);
    assign pins     = '{copy_ok: pin_copy_ok, gen_flag: pin_gen,
                        non_pcm: pin_non_pcm, emph: pin_emph};

    cs_sync_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (frm_sync),
        .edges   (sync_edge)
    );

    cs_shadow_cap #(.FRAMES(FRAMES)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .enable    (src_mode == SRC_SERIAL),
        .edges     (sync_edge),
        .blk_start (blk_start),
        .bit_in    (ser_data),
        .sh_l      (sh_l),
        .sh_r      (sh_r),
        .ptr       (cap_ptr)
    );

    cs_active_buf #(.FRAMES(FRAMES)) u_act (
        .clk      (clk),
        .rst      (rst),
        .load     (blk_start),
        .sh_l     (sh_l),
        .sh_r     (sh_r),
        .rd_idx   (frame_idx),
        .rd_right (sub_right),
        .act_l    (act_l),
        .act_r    (act_r),
        .rd_bit   (ser_bit)
    );

    always_comb begin
        pin_out = pin_bit(pins, int'(frame_idx));
        cs_bit  = (src_mode == SRC_SERIAL) ? ser_bit : pin_out;
    end
endmodule

// File: rtl/cs_bit_source_chk.sv
module cs_bit_source_chk
    import cs_src_pkg::*;
#(
    parameter int unsigned FRAMES = CS_FRAMES,
    localparam int unsigned IDX_W = $clog2(FRAMES),
    localparam int unsigned PTR_W = $clog2(FRAMES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              src_serial,
    input logic              blk_start,
    input logic [IDX_W-1:0]  frame_idx,
    input logic              cs_bit,
    input sync_edge_t        sync_edge,
    input logic [PTR_W-1:0]  cap_ptr,
    input logic [FRAMES-1:0] act_l,
    input logic [FRAMES-1:0] act_r
);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(FRAMES);
    localparam logic [IDX_W:0]   LIMIT = (IDX_W + 1)'(FRAMES);

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_l == '0) && (act_r == '0));

    a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (src_serial && sync_edge.fall && !blk_start && (cap_ptr < LAST))
        |=> (cap_ptr == PTR_W'($past(cap_ptr) + PTR_W'(1))));

    a_r6_ptr_restart: assert property (@(posedge clk) disable iff (rst)
        blk_start |=> (cap_ptr == '0));

    a_r7_active_hold: assert property (@(posedge clk) disable iff (rst)
        !blk_start |=> $stable(act_l) && $stable(act_r));

    a_r8_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        cap_ptr <= LAST);

    a_r9_out_of_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, frame_idx} >= LIMIT) |-> !cs_bit);

    a_r11_pin_hold: assert property (@(posedge clk) disable iff (rst)
        (!src_serial && !blk_start) |=> $stable(cap_ptr));
endmodule

bind cs_bit_source cs_bit_source_chk #(.FRAMES(FRAMES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_serial (src_serial),
    .blk_start  (blk_start),
    .frame_idx  (frame_idx),
    .cs_bit     (cs_bit),
    .sync_edge  (sync_edge),
    .cap_ptr    (cap_ptr),
    .act_l      (act_l),
    .act_r      (act_r)
);

// File: tb/cs_bit_source_tb.sv
module cs_bit_source_tb;
    localparam int NF = 192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_serial = 1'b1;
    logic       frm_sync = 1'b0;
    logic       ser_data = 1'b0;
    logic       blk_start = 1'b0;
    logic       pin_copy_ok = 1'b0, pin_gen = 1'b0, pin_non_pcm = 1'b0, pin_emph = 1'b0;
    logic [7:0] frame_idx = '0;
    logic       sub_right = 1'b0;
    logic       cs_bit;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cs_bit_source u_dut (
        .clk(clk), .rst(rst), .src_serial(src_serial), .frm_sync(frm_sync),
        .ser_data(ser_data), .blk_start(blk_start), .pin_copy_ok(pin_copy_ok),
        .pin_gen(pin_gen), .pin_non_pcm(pin_non_pcm), .pin_emph(pin_emph),
        .frame_idx(frame_idx), .sub_right(sub_right), .cs_bit(cs_bit)
    );

    function automatic logic pat_l(int s, int i);
        return logic'(((i * 5 + s) / 3) % 2);
    endfunction

    function automatic logic pat_r(int s, int i);
        return logic'(((i * 7 + s) % 4) < 2);
    endfunction

    function automatic logic exp_pin(int p, int idx);
        logic c, g, np, e, pro;
        c = p[3]; g = p[2]; np = p[1]; e = p[0];
        pro = c && g;
        case (idx)
            0:  return pro;
            1:  return np;
            2:  return pro ? 1'b1 : c;
            3:  return e;
            15: return pro ? 1'b0 : g;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input logic exp, input string tag, input int idx, input int sub);
        vec++;
        if (cs_bit !== exp) begin
            bad++;
            $display("FAIL %s frame %0d sub %0d: got %b expected %b", tag, idx, sub, cs_bit, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic probe(input int idx, input int sub, input logic exp, input string tag);
        @(negedge clk);
        frame_idx = 8'(idx);
        sub_right = sub[0];
        #1;
        check(exp, tag, idx, sub);
    endtask

    task automatic pulse_blk();
        blk_start = 1'b1;
        tick();
        blk_start = 1'b0;
        tick();
    endtask

    task automatic shift_frame(input logic l, input logic r);
        ser_data = l; frm_sync = 1'b1; tick(); tick();
        ser_data = r; frm_sync = 1'b0; tick(); tick();
    endtask

    task automatic load_block(input int s);
        for (int i = 0; i < NF; i++) shift_frame(pat_l(s, i), pat_r(s, i));
    endtask

    task automatic check_block(input int s, input string tag);
        for (int i = 0; i < NF; i++) begin
            probe(i, 0, pat_l(s, i), tag);
            probe(i, 1, pat_r(s, i), tag);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1: serial mode after reset reads all zero
        for (int i = 0; i < NF; i++) begin
            probe(i, 0, 1'b0, "R1");
            probe(i, 1, 1'b0, "R1");
        end

        // R2 R3 R4 R9: pin-mode sweep over all pin combinations and indices
        src_serial = 1'b0;
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            {pin_copy_ok, pin_gen, pin_non_pcm, pin_emph} = 4'(p);
            for (int idx = 0; idx < 256; idx++) begin
                for (int sub = 0; sub < 2; sub++) begin
                    if (idx >= NF)       probe(idx, sub, 1'b0, "R9");
                    else if (p >= 12)    probe(idx, sub, exp_pin(p, idx), "R2");
                    else if (idx <= 15)  probe(idx, sub, exp_pin(p, idx), "R3");
                    else                 probe(idx, sub, 1'b0, "R4");
                end
            end
        end

        // R5 R6: load first block and commit it
        src_serial = 1'b1;
        tick();
        pulse_blk();
        load_block(1);
        pulse_blk();
        check_block(1, "R5_R6");
        probe(200, 0, 1'b0, "R9");
        probe(255, 1, 1'b0, "R9");

        // R7: shift in a second block, old one still visible
        load_block(6);
        check_block(1, "R7");
        // R8: extra edges beyond 192 frames are ignored
        for (int k = 0; k < 8; k++) shift_frame(~pat_l(6, k), ~pat_r(6, k));
        pulse_blk();
        check_block(6, "R8");

        // R11: edges in pin mode leave the shadow store alone
        src_serial = 1'b0;
        tick();
        for (int k = 0; k < 6; k++) shift_frame(~pat_l(6, k), ~pat_r(6, k));
        src_serial = 1'b1;
        tick();
        pulse_blk();
        check_block(6, "R11");

        // R10: rising edge coinciding with blk_start is dropped
        ser_data = ~pat_l(6, 0);
        frm_sync = 1'b1;
        blk_start = 1'b1;
        tick();
        blk_start = 1'b0;
        tick();
        ser_data = ~pat_r(6, 0);
        frm_sync = 1'b0;
        tick(); tick();
        pulse_blk();
        probe(0, 0, pat_l(6, 0), "R10");
        probe(0, 1, ~pat_r(6, 0), "R10");
        probe(1, 0, pat_l(6, 1), "R10");
        probe(1, 1, pat_r(6, 1), "R10");

        report();
    end
endmodule